// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand for an integer ALU. It also produces the carry bit that logical operations load into the C flag. It is purely combinational. The result and carry settle in the same cycle as the inputs. The block has no clock, no reset and no stored state.

A two-bit form select chooses between three operand forms:
- **Immediate shift:** the operand is shifted by a five-bit amount taken from the instruction word. Here a zero amount has special meanings.
- **Register shift:** the operand is shifted by the low eight bits of another register.
- **Rotated immediate:** a short immediate is rotated right by twice a four-bit field.

A fourth form code passes the operand through untouched. The value shifting is done by a logarithmic barrel network. A separate selector picks the bit that was shifted out last. The top level decodes the zero-amount cases and the saturating cases of 32 or more.

Top module: `operand_shifter`

## Requirements
- R1: `kind_i` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. `form_i` encodes 0 = immediate shift, 1 = register shift, 2 = rotated immediate, 3 = pass-through. Outputs depend only on the current inputs.
- R2: In immediate form, a logical left shift by 0 returns the operand unchanged and passes `carry_i` to `carry_o`.
- R3: In immediate form, an amount of 0 means a shift by 32 for logical right and arithmetic right.
  - Logical right then yields 0.
  - Arithmetic right then fills every bit with operand bit 31.
  - In both cases the carry is operand bit 31.
- R4: In immediate form, rotate right with amount 0 rotates right by one bit through the carry. `carry_i` enters bit 31, and operand bit 0 becomes `carry_o`.
- R5: For a shift by n between 1 and 31, the carry is the last bit shifted out: operand bit 32-n for a left shift, operand bit n-1 for right shifts and rotates. Immediate form uses only `amount_i[4:0]`.
- R6: In register form, an amount of 0 returns the operand unchanged and passes `carry_i` through, for every shift type.
- R7: In register form, logical shifts saturate.
  - An amount of exactly 32 yields 0, with carry equal to operand bit 0 for a left shift and operand bit 31 for a right shift.
  - An amount above 32 yields 0 with carry 0.
- R8: In register form, an arithmetic right shift by 32 or more fills the result with operand bit 31, and the carry equals that bit.
- R9: In register form, a rotate by a nonzero multiple of 32 returns the operand unchanged, with carry equal to operand bit 31. Any other nonzero amount rotates by the amount modulo 32.
- R10: In rotated-immediate form, `operand_i[7:0]` is zero-extended and rotated right by 2×`amount_i[3:0]`. Operand bits above 7, `amount_i[7:4]` and `kind_i` are ignored.
  - When the rotation is nonzero, the carry equals result bit 31.
  - When the rotation is zero, `carry_i` passes through.
- R11: Form code 3 returns the operand unchanged and passes `carry_i` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to shift; low 8 bits are the immediate in rotated-immediate form |
| kind_i | input | 2 | Shift type |
| amount_i | input | 8 | Shift amount, or the rotate field in its low 4 bits |
| form_i | input | 2 | Operand form select |
| carry_i | input | 1 | Incoming C flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Since the block holds no state, a faulty stage or decode shows at the outputs in the same cycle the triggering inputs are applied. It never shows later. Errors tend to hide in a few places:
- a barrel stage that fails to fill correctly shows up only for amounts that set that stage's bit;
- a wrong saturation compare shows up only at amounts 32 and 33 or beyond;
- a wrong carry index shows up only when the neighbouring operand bits differ.

The stimulus therefore pairs a table of hand-worked corner cases with a long pseudo-random sweep against a bit-at-a-time reference. In that sweep, every stage, every amount boundary and every carry position is reached.

// File: rtl/operand_shifter_pkg.sv
package operand_shifter_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      OF_IMM_SHIFT = 2'd0,
      OF_REG_SHIFT = 2'd1,
      OF_ROT_IMM   = 2'd2,
      OF_PASS      = 2'd3
   } operand_form_e;
endpackage

// File: rtl/shifter_core.sv
module shifter_core
   import operand_shifter_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter int SH_BITS = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]   val_i,
   input  shift_kind_e        kind_i,
   input  logic [SH_BITS-1:0] amt_i,
   output logic [WIDTH-1:0]   res_o
);
   logic [WIDTH-1:0] stage_q [SH_BITS+1];

   // One stage per amount bit; stage k moves by 2**k when that bit is set.
   always_comb begin
      stage_q[0] = val_i;
      for (int k = 0; k < SH_BITS; k++) begin
         if (amt_i[k]) begin
            unique case (kind_i)
               SK_LSL:  stage_q[k+1] = stage_q[k] << (1 << k);
               SK_LSR:  stage_q[k+1] = stage_q[k] >> (1 << k);
               SK_ASR:  stage_q[k+1] = WIDTH'($signed(stage_q[k]) >>> (1 << k));
               default: stage_q[k+1] = (stage_q[k] >> (1 << k)) |
                                       (stage_q[k] << (WIDTH - (1 << k)));
            endcase
         end else begin
            stage_q[k+1] = stage_q[k];
         end
      end
   end

   assign res_o = stage_q[SH_BITS];
endmodule

// File: rtl/shifter_carry.sv
module shifter_carry
   import operand_shifter_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter int SH_BITS = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0]   val_i,
   input  shift_kind_e        kind_i,
   input  logic [SH_BITS-1:0] amt_i,
   input  logic               carry_i,
   output logic               carry_o
);
   logic [SH_BITS-1:0] left_idx;
   logic [SH_BITS-1:0] right_idx;

   // Last bit out: index WIDTH-n for left moves, n-1 for right moves.
   assign left_idx  = SH_BITS'(WIDTH) - amt_i;
   assign right_idx = amt_i - SH_BITS'(1);

   always_comb begin
      if (amt_i == '0)
         carry_o = carry_i;
      else if (kind_i == SK_LSL)
         carry_o = val_i[left_idx];
      else
         carry_o = val_i[right_idx];
   end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
   import operand_shifter_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int AMT_BITS  = 8,
   parameter int IMM_BITS  = 8,
   parameter int ROT_BITS  = 4
) (
   input  logic [WIDTH-1:0]    operand_i,
   input  logic [1:0]          kind_i,
   input  logic [AMT_BITS-1:0] amount_i,
   input  logic [1:0]          form_i,
   input  logic                carry_i,
   output logic [WIDTH-1:0]    result_o,
   output logic                carry_o
);
   localparam int SH_BITS = $clog2(WIDTH);

   if ((1 << SH_BITS) != WIDTH) begin : g_bad_width
      $error("operand_shifter: WIDTH must be a power of two");
   end
   if (AMT_BITS <= SH_BITS) begin : g_bad_amt
      $error("operand_shifter: AMT_BITS must exceed log2(WIDTH)");
   end
   if (IMM_BITS > WIDTH || ROT_BITS + 1 > SH_BITS) begin : g_bad_imm
      $error("operand_shifter: immediate fields do not fit the width");
   end

   shift_kind_e        kind;
   operand_form_e      form;
   logic [WIDTH-1:0]   core_val;
   shift_kind_e        core_kind;
   logic [SH_BITS-1:0] core_amt;
   logic [WIDTH-1:0]   core_res;
   logic               core_c;
   logic               use_core;
   logic [WIDTH-1:0]   spec_res;
   logic               spec_c;
   logic               sign;
   logic [SH_BITS-1:0] imm_amt;

   assign kind    = shift_kind_e'(kind_i);
   assign form    = operand_form_e'(form_i);
   assign sign    = operand_i[WIDTH-1];
   assign imm_amt = amount_i[SH_BITS-1:0];

   // Route each form either to the barrel or to a fixed special result.
   always_comb begin
      core_val  = operand_i;
      core_kind = kind;
      core_amt  = imm_amt;
      use_core  = 1'b1;
      spec_res  = operand_i;
      spec_c    = carry_i;
      unique case (form)
         OF_IMM_SHIFT: begin
            if (imm_amt == '0) begin
               unique case (kind)
                  SK_LSL: use_core = 1'b0;
                  SK_LSR: begin use_core = 1'b0; spec_res = '0; spec_c = sign; end
                  SK_ASR: begin use_core = 1'b0; spec_res = {WIDTH{sign}}; spec_c = sign; end
                  default: begin
                     use_core = 1'b0;
                     spec_res = {carry_i, operand_i[WIDTH-1:1]};
                     spec_c   = operand_i[0];
                  end
               endcase
            end
         end
         OF_REG_SHIFT: begin
            if (amount_i == '0) begin
               use_core = 1'b0;
            end else begin
               unique case (kind)
                  SK_LSL, SK_LSR: begin
                     if (amount_i >= AMT_BITS'(WIDTH)) begin
                        use_core = 1'b0;
                        spec_res = '0;
                        if (amount_i == AMT_BITS'(WIDTH))
                           spec_c = (kind == SK_LSL) ? operand_i[0] : sign;
                        else
                           spec_c = 1'b0;
                     end
                  end
                  SK_ASR: begin
                     if (amount_i >= AMT_BITS'(WIDTH)) begin
                        use_core = 1'b0;
                        spec_res = {WIDTH{sign}};
                        spec_c   = sign;
                     end
                  end
                  default: begin
                     if (imm_amt == '0) begin
                        use_core = 1'b0;
                        spec_c   = sign;
                     end
                  end
               endcase
            end
         end
         OF_ROT_IMM: begin
            core_val  = WIDTH'(operand_i[IMM_BITS-1:0]);
            core_kind = SK_ROR;
            core_amt  = SH_BITS'({amount_i[ROT_BITS-1:0], 1'b0});
         end
         default: use_core = 1'b0;
      endcase
   end

   shifter_core #(.WIDTH(WIDTH), .SH_BITS(SH_BITS)) i_core (
      .val_i  (core_val),
      .kind_i (core_kind),
      .amt_i  (core_amt),
      .res_o  (core_res)
   );

   shifter_carry #(.WIDTH(WIDTH), .SH_BITS(SH_BITS)) i_carry (
      .val_i   (core_val),
      .kind_i  (core_kind),
      .amt_i   (core_amt),
      .carry_i (carry_i),
      .carry_o (core_c)
   );

   assign result_o = use_core ? core_res : spec_res;
   assign carry_o  = use_core ? core_c   : spec_c;
endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
   parameter int WIDTH    = 32,
   parameter int AMT_BITS = 8,
   parameter int IMM_BITS = 8
) (
   input logic [WIDTH-1:0]    operand_i,
   input logic [1:0]          kind_i,
   input logic [AMT_BITS-1:0] amount_i,
   input logic [1:0]          form_i,
   input logic                carry_i,
   input logic [WIDTH-1:0]    result_o,
   input logic                carry_o
);
   localparam int SH_BITS = $clog2(WIDTH);

   always_comb begin
      if (form_i == 2'd0 && kind_i == 2'd0 && amount_i[SH_BITS-1:0] == '0) begin
         // R2
         imm_lsl0_chk: assert (result_o == operand_i && carry_o == carry_i);
      end
      if (form_i == 2'd0 && kind_i == 2'd3 && amount_i[SH_BITS-1:0] == '0) begin
         // R4
         rrx_chk: assert (result_o[WIDTH-1] == carry_i && carry_o == operand_i[0]);
      end
      if (form_i == 2'd1 && amount_i == '0) begin
         // R6
         reg_zero_chk: assert (result_o == operand_i && carry_o == carry_i);
      end
      if (form_i == 2'd1 && kind_i[1] == 1'b0 && amount_i > AMT_BITS'(WIDTH)) begin
         // R7
         reg_logic_over_chk: assert (result_o == '0 && carry_o == 1'b0);
      end
      if (form_i == 2'd1 && kind_i == 2'd2 && amount_i >= AMT_BITS'(WIDTH)) begin
         // R8
         reg_asr_sat_chk: assert (result_o == {WIDTH{operand_i[WIDTH-1]}} &&
                                  carry_o == operand_i[WIDTH-1]);
      end
      if (form_i == 2'd2) begin
         // R10
         rot_carry_chk: assert ($countones(result_o) == $countones(operand_i[IMM_BITS-1:0]) &&
                                (amount_i[3:0] == 4'd0 ? carry_o == carry_i
                                                       : carry_o == result_o[WIDTH-1]));
      end
      if (form_i == 2'd3) begin
         // R11
         pass_chk: assert (result_o == operand_i && carry_o == carry_i);
      end
   end
endmodule

bind operand_shifter operand_shifter_chk #(
   .WIDTH(WIDTH), .AMT_BITS(AMT_BITS), .IMM_BITS(IMM_BITS)
) i_operand_shifter_chk (.*);

// File: tb/test_operand_shifter.sv
module test_operand_shifter;
   typedef struct packed {
      logic [3:0]  req;
      logic [1:0]  f;
      logic [1:0]  k;
      logic [7:0]  a;
      logic [31:0] v;
      logic        ci;
      logic [31:0] er;
      logic        ec;
   } vec_t;

   // Encodings of R1 apply to every row: kind 0 LSL,1 LSR,2 ASR,3 ROR; form 0 imm,1 reg,2 rot,3 pass.
   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{4'd2,  2'd0, 2'd0, 8'h00, 32'h8000_0001, 1'b1, 32'h8000_0001, 1'b1}, // R2
      '{4'd5,  2'd0, 2'd0, 8'h04, 32'h1234_5678, 1'b0, 32'h2345_6780, 1'b1}, // R5
      '{4'd5,  2'd0, 2'd0, 8'h1F, 32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1}, // R5
      '{4'd3,  2'd0, 2'd1, 8'h00, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R3
      '{4'd3,  2'd0, 2'd2, 8'h00, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R3
      '{4'd3,  2'd0, 2'd2, 8'h00, 32'h7000_0000, 1'b1, 32'h0000_0000, 1'b0}, // R3
      '{4'd4,  2'd0, 2'd3, 8'h00, 32'h0000_0003, 1'b1, 32'h8000_0001, 1'b1}, // R4
      '{4'd4,  2'd0, 2'd3, 8'h00, 32'h0000_0002, 1'b0, 32'h0000_0001, 1'b0}, // R4
      '{4'd5,  2'd0, 2'd1, 8'h01, 32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1}, // R5
      '{4'd5,  2'd0, 2'd2, 8'h04, 32'hF000_0008, 1'b0, 32'hFF00_0000, 1'b1}, // R5
      '{4'd5,  2'd0, 2'd3, 8'h08, 32'h1234_5678, 1'b1, 32'h7812_3456, 1'b0}, // R5
      '{4'd5,  2'd0, 2'd1, 8'hE1, 32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1}, // R5
      '{4'd6,  2'd1, 2'd0, 8'h00, 32'h0000_0005, 1'b1, 32'h0000_0005, 1'b1}, // R6
      '{4'd6,  2'd1, 2'd3, 8'h00, 32'h0000_0005, 1'b0, 32'h0000_0005, 1'b0}, // R6
      '{4'd7,  2'd1, 2'd0, 8'h20, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1}, // R7
      '{4'd7,  2'd1, 2'd0, 8'h21, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R7
      '{4'd7,  2'd1, 2'd1, 8'h20, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R7
      '{4'd7,  2'd1, 2'd1, 8'hC8, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R7
      '{4'd8,  2'd1, 2'd2, 8'h28, 32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0}, // R8
      '{4'd8,  2'd1, 2'd2, 8'hFF, 32'h8000_0001, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8
      '{4'd9,  2'd1, 2'd3, 8'h40, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b1}, // R9
      '{4'd9,  2'd1, 2'd3, 8'h24, 32'h0000_001F, 1'b0, 32'hF000_0001, 1'b1}, // R9
      '{4'd10, 2'd2, 2'd0, 8'h00, 32'hFFFF_FF81, 1'b1, 32'h0000_0081, 1'b1}, // R10
      '{4'd10, 2'd2, 2'd1, 8'h01, 32'h0000_0003, 1'b0, 32'hC000_0000, 1'b1}, // R10
      '{4'd10, 2'd2, 2'd2, 8'hF8, 32'h0000_007F, 1'b1, 32'h007F_0000, 1'b0}, // R10
      '{4'd11, 2'd3, 2'd2, 8'h10, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b1}  // R11
   };

   logic        clk = 1'b0;
   logic [31:0] operand_i = '0;
   logic [1:0]  kind_i = '0;
   logic [7:0]  amount_i = '0;
   logic [1:0]  form_i = '0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   operand_shifter i_operand_shifter (
      .operand_i(operand_i), .kind_i(kind_i), .amount_i(amount_i),
      .form_i(form_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
   );

   // Bit-at-a-time reference built from the requirements.
   function automatic logic [32:0] model(input logic [1:0] f, input logic [1:0] k,
                                         input logic [7:0] a, input logic [31:0] v,
                                         input logic ci);
      logic [31:0] r = v;
      logic        c = ci;
      int          n = 0;
      if (f == 2'd3) return {ci, v};
      if (f == 2'd2) begin
         r = {24'd0, v[7:0]};
         n = 2 * int'(a[3:0]);
         for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
         if (n != 0) c = r[31];
         return {c, r};
      end
      if (f == 2'd0) begin
         n = int'(a[4:0]);
         if (n == 0 && k == 2'd3) return {v[0], ci, v[31:1]};
         if (n == 0 && k != 2'd0) n = 32;
      end else begin
         n = int'(a);
         if (k == 2'd3 && n != 0) n = (n % 32 == 0) ? 32 : n % 32;
         else if (k == 2'd2 && n > 32) n = 32;
         else if (n > 33) n = 33;
      end
      for (int i = 0; i < n; i++) begin
         case (k)
            2'd0:    begin c = r[31]; r = r << 1; end
            2'd1:    begin c = r[0];  r = r >> 1; end
            2'd2:    begin c = r[0];  r = {r[31], r[31:1]}; end
            default: begin c = r[0];  r = {r[0], r[31:1]}; end
         endcase
      end
      return {c, r};
   endfunction

   task automatic apply(input logic [1:0] f, input logic [1:0] k, input logic [7:0] a,
                        input logic [31:0] v, input logic ci, input logic [31:0] er,
                        input logic ec, input int req);
      @(posedge clk);
      form_i = f; kind_i = k; amount_i = a; operand_i = v; carry_i = ci;
      @(negedge clk);
      checks++;
      if (result_o !== er || carry_o !== ec) begin
         failures++;
         $display("FAIL R%0d form=%0d kind=%0d amt=%0h op=%h cin=%b: got %h/%b expected %h/%b",
                  req, f, k, a, v, ci, result_o, carry_o, er, ec);
      end
   endtask

   initial begin
      logic [31:0] lfsr = 32'h1ACE_B00C;
      logic [32:0] exp_v;
      logic [7:0]  amt;
      // R1: all-zero inputs give zero result and zero carry
      apply(2'd0, 2'd0, 8'd0, 32'd0, 1'b0, 32'd0, 1'b0, 1);
      for (int i = 0; i < NV; i++)
         apply(VECS[i].f, VECS[i].k, VECS[i].a, VECS[i].v, VECS[i].ci,
               VECS[i].er, VECS[i].ec, int'(VECS[i].req));
      // R5 R7 R8 R9: every register amount from 0 to 40 across the shift types
      for (int s = 0; s <= 40; s++) begin
         for (int k = 0; k < 4; k++) begin
            exp_v = model(2'd1, 2'(k), 8'(s), 32'hC3A5_5A3C, 1'b1);
            apply(2'd1, 2'(k), 8'(s), 32'hC3A5_5A3C, 1'b1, exp_v[31:0], exp_v[32], 7);
         end
      end
      // R3 R4 R5 R10: pseudo-random sweep over all forms
      for (int i = 0; i < 1500; i++) begin
         lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
         amt = (lfsr[9:8] == 2'd0) ? {2'b00, lfsr[29:24]} : lfsr[23:16];
         exp_v = model(lfsr[1:0], lfsr[3:2], amt, lfsr ^ 32'h9E37_79B9, lfsr[31]);
         apply(lfsr[1:0], lfsr[3:2], amt, lfsr ^ 32'h9E37_79B9, lfsr[31],
               exp_v[31:0], exp_v[32], 5);
      end
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule